// File: doc/BRIEF.md
# Chained-Autoload DMA Channel Controller

This block is the control part of one DMA channel that sits between a slow legacy peripheral and system memory. Software programs it through three 32-bit words on a simple slave bus: a control/status word, a transfer address and a byte count. Each strobe on the peripheral request input starts one burst on a plain request/acknowledge memory port. A burst is 1, 4, 8 or 16 words long and never runs past the bytes that remain. Each acknowledged word moves the address forward by four and, when counting is on, takes four off the byte count.

The channel can chain transfers. Software turns on the chaining bit. Address and count writes then land in a second, shadow pair instead of the working pair. When the count runs out and the shadow address holds a value, the shadow pair is copied into the working pair and the channel keeps running without a pause. If no shadow pair is waiting, the channel stops. A sticky terminal-count flag and an error flag feed an interrupt, and each flag has its own suppress bit.

Top module: `dmac_chan`

## Requirements
- R1: After hardware reset, the status word reads 0xC000_0000, address and count read 0, and `irq` and `mem_req` are low.
- R2: Word offsets are status 0x0, address 0x4 and count 0x8. With bit 24 clear, writes at 0x4 and 0x8 reach the working registers, and a write at 0x4 sets bit 26 (working address valid). Reads at 0x4 and 0x8 always return the working registers.
- R3: With bit 24 set, writes at 0x4 and 0x8 reach the shadow pair and leave the working pair unchanged. A write at 0x4 sets bit 27 (shadow address valid).
- R4: A `dev_req` pulse is honoured only while bit 25 (running) reads 1. The pulse starts a burst whose word count is picked by bits 19:18 (00 gives 4, 01 gives 8, 10 gives 1, 11 gives 16). When bit 13 is set, the burst is cut to the words that remain. `mem_req` stays high until every word of the burst is acknowledged.
- R5: Every acknowledged word adds 4 to the address. It subtracts 4 from the count only when bit 13 is set.
- R6: When the count drops below one word, bit 14 is set. Writing 1 to bit 14 clears it, and writing 0 leaves it set.
- R7: At terminal count with bits 13 and 24 set and bit 27 set, the shadow pair becomes the working pair on the final acknowledge edge. Bit 27 clears, bits 25 and 26 stay set, and the next burst starts at the reloaded address.
- R8: At terminal count with no valid shadow pair, bits 26 and 25 clear, and later `dev_req` pulses produce no memory request.
- R9: Bit 0 reads (terminal count and not bit 23) or (error and not bit 22). `irq` equals bit 0 AND bit 4.
- R10: `mem_err` on an acknowledged word sets bit 1. Unless bit 22 is set, the burst ends on that word and bit 25 drops. Writing 1 to bit 1 clears it.
- R11: Bit 7 is a soft reset that reads back as written. While it is set, bits 1, 14, 26 and 27 are held at 0 and bit 25 reads 0. A burst already in flight still completes, and bit 10 reads 1 while `mem_req` is high.
- R12: `mem_wr` follows bit 8 (1 moves data from the device to memory).
- R13: Bits 31:28 of the status word read 0xC. Status bits that are not defined read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Slave access strobe |
| bus_wr | input | 1 | Write qualifier for bus_sel |
| bus_addr | input | 4 | Byte offset in the register window (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| dev_req | input | 1 | Peripheral burst request strobe |
| mem_req | output | 1 | Memory word request, held until acknowledged |
| mem_wr | output | 1 | Transfer direction (1: device to memory) |
| mem_addr | output | ADDR_W | Address of the current word |
| mem_ack | input | 1 | Memory accepted the current word |
| mem_err | input | 1 | Error on the acknowledged word |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect on the rising edge that samples it, and read data is combinational, so the bench reads back at the next falling edge. A `dev_req` seen on an edge raises `mem_req` right after that edge. Each acknowledge edge updates the address, the count and the flags, and a terminal-count reload happens on the final acknowledge edge itself, so the new state can be read at the falling edge that follows. The bench drives every input and samples every output on falling edges. It counts acknowledged words in a monitor that follows the memory port, and it checks burst lengths and first addresses only after `mem_req` has fallen.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int WORD_BYTES = 4;
  localparam int BL_W       = 5;

  // status/control word bit positions (software decodes these)
  localparam int B_IPEND  = 0;
  localparam int B_ERR    = 1;
  localparam int B_INTEN  = 4;
  localparam int B_SRST   = 7;
  localparam int B_DIR    = 8;
  localparam int B_EN     = 9;
  localparam int B_CYC    = 10;
  localparam int B_CNTEN  = 13;
  localparam int B_TC     = 14;
  localparam int B_BURST  = 18;
  localparam int B_DERR   = 22;
  localparam int B_TCID   = 23;
  localparam int B_NXT    = 24;
  localparam int B_ON     = 25;
  localparam int B_AVLD   = 26;
  localparam int B_NVLD   = 27;
  localparam int B_ID     = 28;

  localparam logic [3:0] DEV_ID = 4'hC;

  typedef enum logic { ST_IDLE, ST_BURST } eng_state_t;

  function automatic logic [BL_W-1:0] burst_words(input logic [1:0] sel);
    case (sel)
      2'b00:   burst_words = BL_W'(4);
      2'b01:   burst_words = BL_W'(8);
      2'b10:   burst_words = BL_W'(1);
      default: burst_words = BL_W'(16);
    endcase
  endfunction

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [1:0]        rd_sel,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              word_done,
  input  logic              err_hit,
  input  logic              cyc_pend,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              dir,
  output logic              en_cnt,
  output logic [1:0]        burst_sel,
  output logic              dis_err,
  output logic              dma_on,
  output logic              irq
);

  logic [ADDR_W-1:0] addr_d, naddr_q, naddr_d, addr_inc;
  logic [CNT_W-1:0]  cnt_d, ncnt_q, ncnt_d, cnt_dec;
  logic int_en_q, int_en_d, srst_q, srst_d, dir_q, dir_d, en_q, en_d;
  logic cnten_q, cnten_d, tc_q, tc_d, derr_q, derr_d, tcid_q, tcid_d;
  logic nxt_q, nxt_d, avld_q, avld_d, nvld_q, nvld_d, err_q, err_d;
  logic [1:0] bsel_q, bsel_d;
  logic tc_evt, reload, int_pend;

  // next-state logic
  always_comb begin
    addr_d  = addr_q;   cnt_d   = cnt_q;
    naddr_d = naddr_q;  ncnt_d  = ncnt_q;
    int_en_d = int_en_q; srst_d = srst_q; dir_d = dir_q; en_d = en_q;
    cnten_d = cnten_q;  tc_d    = tc_q;   derr_d = derr_q; tcid_d = tcid_q;
    nxt_d   = nxt_q;    avld_d  = avld_q; nvld_d = nvld_q; err_d  = err_q;
    bsel_d  = bsel_q;
    tc_evt  = 1'b0;
    reload  = 1'b0;
    addr_inc = addr_q + ADDR_W'(WORD_BYTES);
    cnt_dec  = cnt_q - CNT_W'(WORD_BYTES);

    if (word_done) begin
      addr_d = addr_inc;
      if (cnten_q) begin
        cnt_d = cnt_dec;
        if (cnt_dec[CNT_W-1:2] == '0) begin
          tc_evt = 1'b1;
          tc_d   = 1'b1;
          if (nxt_q && nvld_q) begin
            reload = 1'b1;
            addr_d = naddr_q;
            cnt_d  = ncnt_q;
            nvld_d = 1'b0;
          end else begin
            avld_d = 1'b0;
          end
        end
      end
    end
    if (err_hit) err_d = 1'b1;

    if (wr_en) begin
      case (wr_sel)
        2'd0: begin
          int_en_d = wdata[B_INTEN];
          srst_d   = wdata[B_SRST];
          dir_d    = wdata[B_DIR];
          en_d     = wdata[B_EN];
          cnten_d  = wdata[B_CNTEN];
          bsel_d   = wdata[B_BURST +: 2];
          derr_d   = wdata[B_DERR];
          tcid_d   = wdata[B_TCID];
          nxt_d    = wdata[B_NXT];
          if (wdata[B_TC] && !tc_evt)   tc_d  = 1'b0;
          if (wdata[B_ERR] && !err_hit) err_d = 1'b0;
        end
        2'd1: begin
          if (nxt_q) begin
            naddr_d = wdata[ADDR_W-1:0];
            nvld_d  = 1'b1;
          end else begin
            addr_d  = wdata[ADDR_W-1:0];
            avld_d  = 1'b1;
          end
        end
        2'd2: begin
          if (nxt_q) ncnt_d = wdata[CNT_W-1:0];
          else       cnt_d  = wdata[CNT_W-1:0];
        end
        default: ;
      endcase
    end

    if (srst_d) begin
      tc_d   = 1'b0;
      err_d  = 1'b0;
      avld_d = 1'b0;
      nvld_d = 1'b0;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; cnt_q <= '0; naddr_q <= '0; ncnt_q <= '0;
      int_en_q <= 1'b0; srst_q <= 1'b0; dir_q <= 1'b0; en_q <= 1'b0;
      cnten_q <= 1'b0; tc_q <= 1'b0; derr_q <= 1'b0; tcid_q <= 1'b0;
      nxt_q <= 1'b0; avld_q <= 1'b0; nvld_q <= 1'b0; err_q <= 1'b0;
      bsel_q <= 2'b00;
    end else begin
      addr_q <= addr_d; cnt_q <= cnt_d; naddr_q <= naddr_d; ncnt_q <= ncnt_d;
      int_en_q <= int_en_d; srst_q <= srst_d; dir_q <= dir_d; en_q <= en_d;
      cnten_q <= cnten_d; tc_q <= tc_d; derr_q <= derr_d; tcid_q <= tcid_d;
      nxt_q <= nxt_d; avld_q <= avld_d; nvld_q <= nvld_d; err_q <= err_d;
      bsel_q <= bsel_d;
    end
  end

  assign dma_on    = en_q & avld_q & ~srst_q & ~(err_q & ~derr_q);
  assign int_pend  = (tc_q & ~tcid_q) | (err_q & ~derr_q);
  assign irq       = int_pend & int_en_q;
  assign dir       = dir_q;
  assign en_cnt    = cnten_q;
  assign burst_sel = bsel_q;
  assign dis_err   = derr_q;

  // read decode
  always_comb begin
    logic [31:0] csr, a_ext, c_ext;
    csr = '0;
    csr[B_IPEND] = int_pend;
    csr[B_ERR]   = err_q;
    csr[B_INTEN] = int_en_q;
    csr[B_SRST]  = srst_q;
    csr[B_DIR]   = dir_q;
    csr[B_EN]    = en_q;
    csr[B_CYC]   = cyc_pend;
    csr[B_CNTEN] = cnten_q;
    csr[B_TC]    = tc_q;
    csr[B_BURST +: 2] = bsel_q;
    csr[B_DERR]  = derr_q;
    csr[B_TCID]  = tcid_q;
    csr[B_NXT]   = nxt_q;
    csr[B_ON]    = dma_on;
    csr[B_AVLD]  = avld_q;
    csr[B_NVLD]  = nvld_q;
    csr[B_ID +: 4] = DEV_ID;
    a_ext = '0;
    a_ext[ADDR_W-1:0] = addr_q;
    c_ext = '0;
    c_ext[CNT_W-1:0] = cnt_q;
    case (rd_sel)
      2'd0:    rdata = csr;
      2'd1:    rdata = a_ext;
      2'd2:    rdata = c_ext;
      default: rdata = '0;
    endcase
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !tc_evt && !wr_en) |=> (addr_q == $past(addr_q) + ADDR_W'(WORD_BYTES))); // R5
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !cnten_q && !wr_en) |=> $stable(cnt_q)); // R5
  AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_q && !wr_en && !srst_q) |=> tc_q); // R6
  AST_RELOAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && reload && !wr_en) |=> (avld_q && !nvld_q && dma_on)); // R7
  AST_TC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && tc_evt && !reload && !wr_en) |=> !dma_on); // R8
  AST_SRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |-> (!avld_q && !nvld_q && !tc_q && !err_q)); // R11

endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
  import dmac_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_req,
  input  logic             dma_on,
  input  logic             en_cnt,
  input  logic [1:0]       burst_sel,
  input  logic [CNT_W-3:0] cnt_words,
  input  logic             dis_err,
  input  logic             mem_ack,
  input  logic             mem_err,
  output logic             mem_req,
  output logic             word_done,
  output logic             err_hit
);

  localparam int RW = CNT_W - 2;

  eng_state_t       st_q, st_d;
  logic [BL_W-1:0]  left_q, left_d, bl, len;
  logic             pend_q, pend_d, start;

  always_comb begin
    bl  = burst_words(burst_sel);
    len = bl;
    if (en_cnt && (cnt_words < RW'(bl))) len = cnt_words[BL_W-1:0];
    start = (st_q == ST_IDLE) && (dev_req || pend_q) && dma_on && (len != '0);
  end

  always_comb begin
    st_d   = st_q;
    left_d = left_q;
    pend_d = (pend_q | dev_req) & dma_on;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_BURST;
          left_d = len;
          pend_d = 1'b0;
        end
      end
      ST_BURST: begin
        if (mem_ack) begin
          left_d = left_q - BL_W'(1);
          if ((left_q == BL_W'(1)) || (mem_err && !dis_err)) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
      pend_q <= pend_d;
    end
  end

  assign mem_req   = (st_q == ST_BURST);
  assign word_done = mem_req & mem_ack;
  assign err_hit   = word_done & mem_err;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req); // R4
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((left_q != '0) && (left_q <= BL_W'(16)))); // R4
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(dma_on)); // R8
  AST_ERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err && !dis_err) |=> !mem_req); // R10

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dev_req,
  output logic              mem_req,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              irq
);

  logic              rst_meta_q, rst_sync_q;
  logic              wr_en, word_done, err_hit, dma_on, en_cnt, dis_err, dir;
  logic [1:0]        burst_sel;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign wr_en = bus_sel & bus_wr & (bus_addr[1:0] == 2'b00);

  dmac_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .wr_en     (wr_en),
    .wr_sel    (bus_addr[3:2]),
    .rd_sel    (bus_addr[3:2]),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .word_done (word_done),
    .err_hit   (err_hit),
    .cyc_pend  (mem_req),
    .addr_q    (addr_q),
    .cnt_q     (cnt_q),
    .dir       (dir),
    .en_cnt    (en_cnt),
    .burst_sel (burst_sel),
    .dis_err   (dis_err),
    .dma_on    (dma_on),
    .irq       (irq)
  );

  dmac_engine #(.CNT_W(CNT_W)) eng_i (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .dev_req   (dev_req),
    .dma_on    (dma_on),
    .en_cnt    (en_cnt),
    .burst_sel (burst_sel),
    .cnt_words (cnt_q[CNT_W-1:2]),
    .dis_err   (dis_err),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .mem_req   (mem_req),
    .word_done (word_done),
    .err_hit   (err_hit)
  );

  assign mem_addr = addr_q;
  assign mem_wr   = dir;

endmodule

// File: tb/dmac_chan_tb.sv
`timescale 1ns/1ps
module dmac_chan_tb_top;

  localparam logic [31:0] K_ID   = 32'hC000_0000;
  localparam logic [31:0] K_IP   = 32'h1 << 0;
  localparam logic [31:0] K_ERR  = 32'h1 << 1;
  localparam logic [31:0] K_IEN  = 32'h1 << 4;
  localparam logic [31:0] K_SRST = 32'h1 << 7;
  localparam logic [31:0] K_DIR  = 32'h1 << 8;
  localparam logic [31:0] K_EN   = 32'h1 << 9;
  localparam logic [31:0] K_CYC  = 32'h1 << 10;
  localparam logic [31:0] K_CEN  = 32'h1 << 13;
  localparam logic [31:0] K_TC   = 32'h1 << 14;
  localparam logic [31:0] K_B8   = 32'h1 << 18;
  localparam logic [31:0] K_B16  = 32'h3 << 18;
  localparam logic [31:0] K_DERR = 32'h1 << 22;
  localparam logic [31:0] K_TCID = 32'h1 << 23;
  localparam logic [31:0] K_NXT  = 32'h1 << 24;
  localparam logic [31:0] K_ON   = 32'h1 << 25;
  localparam logic [31:0] K_AV   = 32'h1 << 26;
  localparam logic [31:0] K_NV   = 32'h1 << 27;

  logic clk, rst_n, bus_sel, bus_wr, dev_req, mem_req, mem_wr, mem_ack, mem_err, irq;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, mem_addr;
  logic ack_en, beat_clr, any_wr, finished;
  logic [31:0] first_addr;
  int beats, err_beat, n_chk, n_fail;

  dmac_chan dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_req(dev_req), .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign mem_ack = mem_req & ack_en;
  assign mem_err = mem_ack & (beats == err_beat);

  always @(posedge clk) begin
    if (beat_clr) begin
      beats <= 0; any_wr <= 1'b0; first_addr <= '0;
    end else if (mem_req && mem_ack) begin
      if (beats == 0) first_addr <= mem_addr;
      beats <= beats + 1;
      if (mem_wr) any_wr <= 1'b1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = off; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] off, output logic [31:0] v);
    @(negedge clk);
    bus_addr = off;
    #1 v = bus_rdata;
  endtask

  task automatic pulse_req();
    beat_clr = 1'b1;
    @(negedge clk);
    beat_clr = 1'b0; dev_req = 1'b1;
    @(negedge clk);
    dev_req = 1'b0;
  endtask

  task automatic burst();
    pulse_req();
    for (int i = 0; i < 200 && mem_req; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h0, v); chk("R1", "status after reset", v, K_ID);
    rd(4'h4, v); chk("R1", "address after reset", v, 32'h0);
    rd(4'h8, v); chk("R1", "count after reset", v, 32'h0);
    chk("R1", "irq/mem_req after reset", {30'h0, irq, mem_req}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(4'h4, 32'h1000); wr(4'h8, 32'h40);
    rd(4'h4, v); chk("R2", "working address", v, 32'h1000);
    rd(4'h8, v); chk("R2", "working count", v, 32'h40);
    wr(4'h0, 32'h0000_006C);
    rd(4'h0, v); chk("R13", "id and undefined bits", v, K_ID | K_AV);
  endtask

  task automatic t_shadow();
    logic [31:0] v;
    wr(4'h0, K_NXT | K_CEN);
    wr(4'h4, 32'h2000); wr(4'h8, 32'h10);
    rd(4'h4, v); chk("R3", "working address untouched", v, 32'h1000);
    rd(4'h8, v); chk("R3", "working count untouched", v, 32'h40);
    rd(4'h0, v); chk("R3", "shadow valid flag", v, K_ID | K_AV | K_NV | K_NXT | K_CEN);
  endtask

  task automatic t_bursts();
    logic [31:0] v, base;
    base = K_NXT | K_CEN | K_EN | K_DIR;
    wr(4'h0, base);
    rd(4'h0, v); chk("R4", "running flag", v & K_ON, K_ON);
    burst();
    chk("R4", "4-word burst length", beats, 4);
    chk("R4", "first address", first_addr, 32'h1000);
    chk("R12", "direction device to memory", {31'h0, any_wr}, 32'h1);
    rd(4'h4, v); chk("R5", "address after 4 words", v, 32'h1010);
    rd(4'h8, v); chk("R5", "count after 4 words", v, 32'h30);
    wr(4'h0, base | K_B8);
    burst();
    chk("R4", "8-word burst length", beats, 8);
    rd(4'h4, v); chk("R5", "address after 8 words", v, 32'h1030);
    rd(4'h8, v); chk("R5", "count after 8 words", v, 32'h10);
  endtask

  task automatic t_reload();
    logic [31:0] v, base;
    base = K_NXT | K_CEN | K_EN | K_DIR | K_B16;
    wr(4'h0, base);
    burst();
    chk("R4", "16-word burst cut to remainder", beats, 4);
    chk("R4", "remainder burst start", first_addr, 32'h1030);
    rd(4'h4, v); chk("R7", "reloaded address", v, 32'h2000);
    rd(4'h8, v); chk("R7", "reloaded count", v, 32'h10);
    rd(4'h0, v);
    chk("R7", "flags after reload", v & (K_NV | K_AV | K_ON), K_AV | K_ON);
    chk("R6", "terminal count set", v & K_TC, K_TC);
    chk("R9", "pending without enable", {v[0], irq}, {30'h0, 2'b10});
    wr(4'h0, base);
    rd(4'h0, v); chk("R6", "write 0 keeps terminal count", v & K_TC, K_TC);
    wr(4'h0, base | K_TC);
    rd(4'h0, v); chk("R6", "write 1 clears terminal count", v & (K_TC | K_IP), 32'h0);
    burst();
    chk("R7", "burst at reloaded address", first_addr, 32'h2000);
    chk("R7", "reloaded burst length", beats, 4);
    rd(4'h0, v); chk("R8", "stopped without shadow", v & (K_AV | K_ON | K_TC), K_TC);
    rd(4'h8, v); chk("R8", "count exhausted", v, 32'h0);
    pulse_req();
    repeat (8) @(negedge clk);
    chk("R8", "request ignored once stopped", beats, 0);
    wr(4'h0, base | K_IEN);
    #1 chk("R9", "irq on terminal count", {31'h0, irq}, 32'h1);
    wr(4'h0, base | K_IEN | K_TCID);
    rd(4'h0, v); chk("R9", "terminal count interrupt suppressed", {v[0], irq}, 32'h0);
    wr(4'h0, base | K_TC);
  endtask

  task automatic t_error();
    logic [31:0] v, base;
    base = K_CEN | K_EN | K_IEN | K_B8;
    wr(4'h0, base);
    wr(4'h4, 32'h3000); wr(4'h8, 32'h20);
    err_beat = 1;
    burst();
    chk("R10", "burst ends at failing word", beats, 2);
    chk("R12", "direction memory to device", {31'h0, any_wr}, 32'h0);
    rd(4'h0, v); chk("R10", "error flags", v & (K_ERR | K_ON | K_IP), K_ERR | K_IP);
    chk("R9", "irq on error", {31'h0, irq}, 32'h1);
    rd(4'h4, v); chk("R5", "address after error", v, 32'h3008);
    wr(4'h0, base | K_ERR);
    rd(4'h0, v); chk("R10", "error cleared, running again", v & (K_ERR | K_ON), K_ON);
    base = K_CEN | K_EN | K_IEN | K_B8 | K_DERR | K_TCID;
    wr(4'h0, base);
    err_beat = 0;
    burst();
    err_beat = 99;
    chk("R10", "error ignored with bit 22", beats, 6);
    rd(4'h0, v); chk("R9", "both causes suppressed", v & (K_ERR | K_TC | K_IP | K_ON), K_ERR | K_TC);
    chk("R9", "irq quiet", {31'h0, irq}, 32'h0);
    wr(4'h0, base | K_ERR | K_TC);
  endtask

  task automatic t_srst();
    logic [31:0] v;
    wr(4'h4, 32'h4000); wr(4'h8, 32'h40);
    wr(4'h0, K_CEN | K_EN);
    ack_en = 1'b0;
    pulse_req();
    chk("R11", "burst in flight", {31'h0, mem_req}, 32'h1);
    wr(4'h0, K_CEN | K_EN | K_SRST);
    rd(4'h0, v); chk("R11", "soft reset state", v & (K_SRST | K_CYC | K_AV | K_ON), K_SRST | K_CYC);
    ack_en = 1'b1;
    for (int i = 0; i < 50 && mem_req; i++) @(negedge clk);
    chk("R11", "in-flight burst completes", beats, 4);
    rd(4'h0, v); chk("R11", "cycle pending clear", v & K_CYC, 32'h0);
    rd(4'h4, v); chk("R11", "address advanced", v, 32'h4010);
    pulse_req();
    repeat (4) @(negedge clk);
    chk("R11", "no start in soft reset", beats, 0);
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R11", "soft reset released", v, K_ID);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    finished = 1'b0;
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; err_beat = 99;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    dev_req = 1'b0; ack_en = 1'b1; beat_clr = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    beat_clr = 1'b0;
    t_reset();
    t_regs();
    t_shadow();
    t_bursts();
    t_reload();
    t_error();
    t_srst();
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule